// File: doc/BRIEF.md
# Timer Compare/Capture Pin Controller

This block is one channel of a general-purpose timer. A free-running up-counter advances on each cycle in which its count enable is high. A general register is either compared against the counter or loaded from it. A 4-bit mode field decides which role that register plays. In compare roles the block owns an output pin. The pin takes a chosen starting level when the mode is written. On every later compare match it is forced low, forced high or inverted. In capture roles the pin is released. The register then samples the counter when a selected edge arrives on a synchronized input pin. In the cascade-capable variant, it can instead sample the counter on an event strobe from a neighbouring channel.

Every compare match and every capture raises a sticky event flag. Software clears the flag with a one-cycle clear strobe. The pin level is held by a four-state machine:

- **PIN_OFF**: the output is disabled.
- **PIN_LOW**: the output drives 0.
- **PIN_HIGH**: the output drives 1.
- **PIN_CAPT**: the channel is in a capture role.

The machine has three transitions:

- **T_WRITE**: a mode write, taken from any state to the state the new mode selects.
- **T_RAISE**: PIN_LOW to PIN_HIGH, on a match whose action is set or invert.
- **T_DROP**: PIN_HIGH to PIN_LOW, on a match whose action is clear or invert.

Every other cycle holds the current state.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset the counter, the general register and the mode field are 0, `pin_oe` and `pin_out` are 0 and `flag` is 0.
- R2: Writing a mode with bit 3 = 0 and bits [1:0] ≠ 00 makes `pin_oe` = 1 in the next cycle, with `pin_out` equal to mode bit 2 (the starting level).
- R3: A compare match is a cycle with `cnt_en` = 1 and `cnt_q` equal to `gr_q` while mode bit 3 = 0. In the following cycle, an output-mode pin is driven to 0 when bits [1:0] = 01, to 1 when they are 10, and inverted when they are 11.
- R4: Modes 0000 and 0100 keep `pin_oe` = 0 and `pin_out` = 0. A compare match in these modes still sets the flag and leaves the pin unchanged.
- R5: `flag` becomes 1 in the cycle after a compare match or a capture. It stays 1 until `flag_clr` is pulsed, which clears it in the next cycle. When a set and a clear coincide, the set wins.
- R6: `cnt_q` rises by one, wrapping at its width, after each cycle with `cnt_en` = 1, and holds otherwise.
- R7: With mode bit 3 = 1 the register is a capture register, `pin_oe` = 0 and `pin_out` = 0.
- R8: In pin-capture modes `cap_pin` passes two synchronizer flops. Bits [1:0] = 00 select rising edges, 01 falling edges, and 1x both edges. The register shows, three cycles after the pin changes, the counter value from the second cycle after the change. Edges of the unselected polarity leave the register and the flag unchanged.
- R9: With `CASCADE` = 1, mode 11xx captures on the `nbr_evt` strobe. `gr_q` shows in the next cycle the counter value of the strobe cycle, and pin edges are ignored.
- R10: With `CASCADE` = 0, mode bit 2 is ignored in capture modes, so 1100 captures on rising pin edges and `nbr_evt` has no effect.
- R11: A `reg_we` pulse loads `reg_wdata` into `gr_q` in the next cycle. A capture in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter increment enable |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 4 | New mode field value |
| reg_we | input | 1 | General register write strobe |
| reg_wdata | input | CNT_W | New general register value |
| cap_pin | input | 1 | Asynchronous capture input pin |
| nbr_evt | input | 1 | One-cycle event strobe from the neighbouring channel |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cnt_q | output | CNT_W | Counter value |
| gr_q | output | CNT_W | General register value |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin enable |
| flag | output | 1 | Sticky match/capture flag |

## Verification
All six active output modes are tried against a single compare match. Each starts from a different level, so that forcing the pin to the level it already has is told apart from actually changing it. The invert mode is run through two matches to show that inversion stacks. Capture is exercised with rising-only, falling-only and both-edge modes, each fed both polarities, so that a wrongly selected polarity shows as a missed or an extra load. The counter runs during every capture, so the exact pipeline latency shows in the captured value. The cascade mode is driven with a pin edge and a neighbour strobe at once on a cascade-capable and a non-cascade instance. This separates the two meanings of mode bit 2.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        PIN_OFF,
        PIN_LOW,
        PIN_HIGH,
        PIN_CAPT
    } pin_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_CLR,
        ACT_SET,
        ACT_TGL
    } match_act_e;

    // State entered when the mode field is written with value m.
    function automatic pin_state_e entry_state(input logic [MODE_W-1:0] m);
        if (m[3])
            return PIN_CAPT;
        else if (m[1:0] == 2'b00)
            return PIN_OFF;
        else if (m[2])
            return PIN_HIGH;
        else
            return PIN_LOW;
    endfunction

endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    output logic [W-1:0] cnt_q
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_en)
            cnt_q <= cnt_q + ONE;
    end

endmodule

// File: rtl/tmr_cap_sync.sv
module tmr_cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], pin_in};
    end

    assign rise =  chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] &  chain[STAGES];

endmodule

// File: rtl/tmr_pin_fsm.sv
module tmr_pin_fsm
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  match_act_e        act,
    input  logic              cmp_hit,
    output logic              pin_out,
    output logic              pin_oe
);

    pin_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PIN_OFF;
        else
            state_q <= state_d;
    end

    // transitions: T_WRITE, T_RAISE, T_DROP
    always_comb begin
        state_d = state_q;
        if (mode_we) begin
            state_d = entry_state(mode_wdata);
        end else if (cmp_hit) begin
            unique case (state_q)
                PIN_LOW:  if (act == ACT_SET || act == ACT_TGL) state_d = PIN_HIGH;
                PIN_HIGH: if (act == ACT_CLR || act == ACT_TGL) state_d = PIN_LOW;
                PIN_OFF:  state_d = PIN_OFF;
                PIN_CAPT: state_d = PIN_CAPT;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PIN_LOW:  begin pin_oe = 1'b1; pin_out = 1'b0; end
            PIN_HIGH: begin pin_oe = 1'b1; pin_out = 1'b1; end
            PIN_OFF:  begin pin_oe = 1'b0; pin_out = 1'b0; end
            PIN_CAPT: begin pin_oe = 1'b0; pin_out = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit CASCADE     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_en,
    input  logic                  mode_we,
    input  logic [MODE_W-1:0]     mode_wdata,
    input  logic                  reg_we,
    input  logic [CNT_W-1:0]      reg_wdata,
    input  logic                  cap_pin,
    input  logic                  nbr_evt,
    input  logic                  flag_clr,
    output logic [CNT_W-1:0]      cnt_q,
    output logic [CNT_W-1:0]      gr_q,
    output logic                  pin_out,
    output logic                  pin_oe,
    output logic                  flag
);

    logic [MODE_W-1:0] mode_q;
    logic              cmp_hit;
    logic              cap_hit;
    logic              edge_hit;
    logic              use_nbr;
    logic              pin_rise;
    logic              pin_fall;
    logic              evt;

    tmr_free_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .cnt_q  (cnt_q)
    );

    tmr_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (cap_pin),
        .rise   (pin_rise),
        .fall   (pin_fall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_we)
            mode_q <= mode_wdata;
    end

    assign cmp_hit = cnt_en && !mode_q[3] && (cnt_q == gr_q);

    generate
        if (CASCADE) begin : g_cascade
            assign use_nbr = mode_q[2];
        end else begin : g_plain
            assign use_nbr = 1'b0;
        end
    endgenerate

    always_comb begin
        if (mode_q[1])
            edge_hit = pin_rise | pin_fall;
        else if (mode_q[0])
            edge_hit = pin_fall;
        else
            edge_hit = pin_rise;
    end

    assign cap_hit = mode_q[3] && (use_nbr ? nbr_evt : edge_hit);

    // capture wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)
            gr_q <= '0;
        else if (cap_hit)
            gr_q <= cnt_q;
        else if (reg_we)
            gr_q <= reg_wdata;
    end

    assign evt = cmp_hit | cap_hit;

    // set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (evt)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    tmr_pin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .act        (match_act_e'(mode_q[1:0])),
        .cmp_hit    (cmp_hit),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

endmodule

// File: rtl/tmr_pin_ctrl_chk.sv
module tmr_pin_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             mode_we,
    input logic [3:0]       mode_wdata,
    input logic [3:0]       mode_q,
    input logic             flag_clr,
    input logic             evt,
    input logic             cap_hit,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] gr_q,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             flag
);

    AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !mode_wdata[3] && mode_wdata[1:0] != 2'b00)
        |=> (pin_oe && pin_out == $past(mode_wdata[2]))); // R2

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out); // R4

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag); // R5

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R5

    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !evt) |=> !flag); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_q)); // R6

    AST_CAPT_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[3] |-> !pin_oe); // R7

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> gr_q == $past(cnt_q)); // R8

endmodule

bind tmr_pin_ctrl tmr_pin_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .mode_q     (mode_q),
    .flag_clr   (flag_clr),
    .evt        (evt),
    .cap_hit    (cap_hit),
    .cnt_q      (cnt_q),
    .gr_q       (gr_q),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .flag       (flag)
);

// File: tb/tmr_pin_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_pin_ctrl_bench;

    localparam int W = 16;
    localparam int S_PIN = 0, S_OE = 1, S_GR = 2, S_FLAG = 3, S_CNT = 4, S_GRNC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0, mode_we = 1'b0, reg_we = 1'b0;
    logic cap_pin = 1'b0, nbr_evt = 1'b0, flag_clr = 1'b0;
    logic [3:0]   mode_wdata = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] cnt_q, gr_q, cnt_nc, gr_nc;
    logic pin_out, pin_oe, flag, pin_out_nc, pin_oe_nc, flag_nc;

    always #2.5 clk = ~clk;

    tmr_pin_ctrl #(.CNT_W(W), .CASCADE(1'b1)) u_tmr_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .cap_pin(cap_pin), .nbr_evt(nbr_evt), .flag_clr(flag_clr),
        .cnt_q(cnt_q), .gr_q(gr_q), .pin_out(pin_out), .pin_oe(pin_oe), .flag(flag));

    tmr_pin_ctrl #(.CNT_W(W), .CASCADE(1'b0)) u_tmr_pin_ctrl_nc (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .cap_pin(cap_pin), .nbr_evt(nbr_evt), .flag_clr(flag_clr),
        .cnt_q(cnt_nc), .gr_q(gr_nc), .pin_out(pin_out_nc), .pin_oe(pin_oe_nc), .flag(flag_nc));

    typedef struct {
        int          cyc;
        int          sig;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int cur_cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [W-1:0] mcnt;
    logic [W-1:0] exp_gr = '0;
    logic [W-1:0] exp_gr_nc = '0;

    always @(posedge clk) cur_cyc <= cur_cyc + 1;

    // bench model of the counter, from R6
    always @(posedge clk) begin
        if (!rst_n)
            mcnt <= '0;
        else if (cnt_en)
            mcnt <= mcnt + 16'd1;
    end

    function automatic logic [31:0] sample(int s);
        case (s)
            S_PIN:   return {31'b0, pin_out};
            S_OE:    return {31'b0, pin_oe};
            S_GR:    return {16'b0, gr_q};
            S_FLAG:  return {31'b0, flag};
            S_CNT:   return {16'b0, cnt_q};
            default: return {16'b0, gr_nc};
        endcase
    endfunction

    // monitor: pops due items and compares them
    always @(negedge clk) begin
        exp_t it;
        logic [31:0] act;
        while (sbq.size() > 0 && sbq[0].cyc <= cur_cyc) begin
            it = sbq.pop_front();
            act = sample(it.sig);
            checks++;
            if (act !== it.val) begin
                fails++;
                $display("FAIL %s sig%0d cycle %0d: actual %0h expected %0h",
                         it.req, it.sig, cur_cyc, act, it.val);
            end
        end
    end

    task automatic expect_at(int dcyc, int sig, logic [31:0] v, string req);
        exp_t item;
        int i;
        item = '{cur_cyc + dcyc, sig, v, req};
        i = sbq.size();
        while (i > 0 && sbq[i-1].cyc > item.cyc) i--;
        sbq.insert(i, item);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_mode(logic [3:0] m, logic exp_oe, logic exp_pin, string req);
        mode_we = 1'b1;
        mode_wdata = m;
        expect_at(1, S_OE, exp_oe, req);
        expect_at(1, S_PIN, exp_pin, req);
        step();
        mode_we = 1'b0;
    endtask

    task automatic write_gr(logic [W-1:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        expect_at(1, S_GR, v, "R11");
        step();
        reg_we = 1'b0;
        exp_gr = v;
        exp_gr_nc = v;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        expect_at(1, S_FLAG, 0, "R5");
        step();
        flag_clr = 1'b0;
    endtask

    // counter frozen on entry; match occurs 4 cycles after the run starts
    task automatic match_run(logic pre, logic post, string req);
        logic [W-1:0] g;
        g = mcnt + 16'd4;
        write_gr(g);
        cnt_en = 1'b1;
        expect_at(4, S_PIN, pre, req);
        expect_at(5, S_PIN, post, req);
        expect_at(5, S_FLAG, 1, "R5");
        step(5);
        cnt_en = 1'b0;
    endtask

    // counter running; pin changes now
    task automatic cap_edge(logic lvl, bit hits, string req);
        logic [W-1:0] t;
        clear_flag();
        t = mcnt + 16'd2;
        cap_pin = lvl;
        if (hits) begin
            expect_at(2, S_GR, exp_gr, req);
            expect_at(3, S_GR, t, req);
            expect_at(3, S_FLAG, 1, req);
            exp_gr = t;
            exp_gr_nc = t;
        end else begin
            expect_at(4, S_GR, exp_gr, req);
            expect_at(4, S_FLAG, 0, req);
        end
        step(5);
    endtask

    initial begin
        logic [W-1:0] t;
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(0, S_OE, 0, "R1");
        expect_at(0, S_PIN, 0, "R1");
        expect_at(0, S_FLAG, 0, "R1");
        expect_at(0, S_GR, 0, "R1");
        expect_at(0, S_CNT, 0, "R1");
        step();

        // R2/R3 output modes
        write_mode(4'b0001, 1, 0, "R2");
        match_run(0, 0, "R3");
        clear_flag();
        write_mode(4'b0101, 1, 1, "R2");
        match_run(1, 0, "R3");
        clear_flag();
        write_mode(4'b0010, 1, 0, "R2");
        match_run(0, 1, "R3");
        clear_flag();
        write_mode(4'b0110, 1, 1, "R2");
        match_run(1, 1, "R3");
        clear_flag();
        write_mode(4'b0011, 1, 0, "R2");
        match_run(0, 1, "R3");
        match_run(1, 0, "R3");
        clear_flag();
        write_mode(4'b0111, 1, 1, "R2");
        match_run(1, 0, "R3");
        clear_flag();

        // R4 disabled output modes still flag matches
        write_mode(4'b0100, 0, 0, "R4");
        match_run(0, 0, "R4");
        expect_at(0, S_OE, 0, "R4");
        clear_flag();
        write_mode(4'b0000, 0, 0, "R4");
        match_run(0, 0, "R4");

        // R5 set wins over clear (flag is 1 here)
        t = mcnt + 16'd2;
        write_gr(t);
        cnt_en = 1'b1;
        flag_clr = 1'b1;
        expect_at(1, S_FLAG, 0, "R5");
        expect_at(3, S_FLAG, 1, "R5");
        step(3);
        flag_clr = 1'b0;
        cnt_en = 1'b0;
        expect_at(2, S_FLAG, 1, "R5");
        step(2);

        // R6 counter holds, then runs
        expect_at(0, S_CNT, mcnt, "R6");
        step(3);
        expect_at(0, S_CNT, mcnt, "R6");
        cnt_en = 1'b1;
        expect_at(3, S_CNT, mcnt + 16'd3, "R6");
        step(3);

        // R7 capture mode releases the pin; R8 edge selection
        clear_flag();
        write_mode(4'b1000, 0, 0, "R7");
        cap_edge(1'b1, 1'b1, "R8");
        cap_edge(1'b0, 1'b0, "R8");
        write_mode(4'b1001, 0, 0, "R7");
        cap_edge(1'b1, 1'b0, "R8");
        cap_edge(1'b0, 1'b1, "R8");
        write_mode(4'b1010, 0, 0, "R7");
        cap_edge(1'b1, 1'b1, "R8");
        cap_edge(1'b0, 1'b1, "R8");

        // R9 cascade source vs R10 non-cascade variant
        write_mode(4'b1100, 0, 0, "R7");
        clear_flag();
        t = mcnt + 16'd2;
        cap_pin = 1'b1;
        expect_at(4, S_GR, exp_gr, "R9");
        expect_at(4, S_FLAG, 0, "R9");
        expect_at(3, S_GRNC, t, "R10");
        step(5);
        exp_gr_nc = t;
        nbr_evt = 1'b1;
        expect_at(1, S_GR, mcnt, "R9");
        expect_at(1, S_FLAG, 1, "R9");
        expect_at(2, S_GRNC, exp_gr_nc, "R10");
        exp_gr = mcnt;
        step();
        nbr_evt = 1'b0;
        step(2);

        // R11 capture beats a same-cycle write
        nbr_evt = 1'b1;
        reg_we = 1'b1;
        reg_wdata = 16'hBEEF;
        expect_at(1, S_GR, mcnt, "R11");
        step();
        nbr_evt = 1'b0;
        reg_we = 1'b0;

        while (sbq.size() > 0) step();
        step(2);
        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule